// File: doc/BRIEF.md
# Strobe Activity Watchdog

This block watches a strobe line driven by a processor and raises a timeout request when the line stops changing for too long. Software keeps the system alive by toggling the strobe. Every change of level, rising or falling, restarts the count. If the count reaches the selected limit with no change, the block issues a one-cycle request, and the surrounding reset generator turns that request into a system reset.

The strobe is asynchronous to the system clock, so it passes through a synchronizer before edge detection. The reset generator reports its current state on `rstActive`. While that input is high, the counter stays at zero, and it only starts counting once reset is released. A disable input stands for a strobe driver that is floating or tri-stated. It suppresses the request but lets the counter keep running.

Four timeout lengths are available. Each is sixteen times the one below it, and the shortest is set by a clock-based parameter.

Top module: `strobe_watchdog`

## Requirements
- R1: With `rstActive` low, `wdDisable` low and no strobe transition, `timeoutReq` goes high exactly T cycles after counting starts. T is the terminal count chosen by `timeoutSel`. Counting starts on the first clock edge that samples `rstActive` low.
- R2: The terminal count is T = BASE_TICKS << (4 * timeoutSel). Select value 0 gives the shortest period and value 3 the longest.
- R3: A rising transition on `strobeIn` clears the counter on the third clock edge after the input changes: two synchronizer flops, then the edge register. The next request therefore comes 3 + T cycles after the change.
- R4: A falling transition on `strobeIn` clears the counter with the same 3 + T cycle timing as a rising transition.
- R5: While `rstActive` is high, the counter is held at zero and no request is issued, however long reset lasts.
- R6: When the reset raised by the block's own timeout is reported back on `rstActive`, the counter is cleared. After reset is released, a full T cycles pass before the next request.
- R7: While `wdDisable` is high, no request is issued, but the counter keeps advancing. If the disable is dropped at cycle k of a count, the request still arrives at cycle T. If the count has already reached T, no request comes at all.
- R8: `timeoutReq` is high for exactly one cycle. The counter then saturates at T, and no further request is issued until a strobe transition or `rstActive` clears it.
- R9: A strobe pulse lasting a single clock cycle is detected as a transition and clears the counter.
- R10: While `rst_n` is low, and right after it is released with `rstActive` high, `timeoutReq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's registers |
| strobeIn | input | 1 | Asynchronous keep-alive strobe from the processor |
| wdDisable | input | 1 | High when the strobe driver is floating or tri-stated; masks the request |
| rstActive | input | 1 | High while the reset generator holds the system in reset |
| timeoutSel | input | 2 | Timeout choice, 0 (shortest) to 3 (longest) |
| timeoutReq | output | 1 | One-cycle timeout request to the reset generator |

## Verification
A request is due exactly T cycles after the first clock edge that sees `rstActive` low. After a strobe change, it is due 3 + T cycles later, because the change passes two synchronizer flops and the edge register before it clears the count. The bench applies every input at a falling clock edge and then counts falling edges. On each one it samples `timeoutReq`, records the index of the first high sample and counts how many samples are high. It compares that index with T or with 3 + T, and it checks that exactly one sample is high, or none where R5, R7 or R8 call for silence.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // force the count to zero
    logic advance;  // increment the count
  } wdtCtl_t;

  // Status from datapath to control
  typedef struct packed {
    logic edgeSeen;  // synchronized strobe changed level
    logic nearTerm;  // count is one below the terminal value
    logic atTerm;    // count has reached (or passed) the terminal value
  } wdtStat_t;

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter longint unsigned BASE_TICKS  = 64'd1_575_000,
  parameter int              SEL_W       = 2,
  parameter int              SEL_SHIFT   = 4,
  parameter int              SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobeIn,
  input  logic [SEL_W-1:0] timeoutSel,
  input  wdtCtl_t          ctl,
  output wdtStat_t         stat
);

  localparam int              NUM_SEL  = 1 << SEL_W;
  localparam longint unsigned MAX_TERM = BASE_TICKS << (SEL_SHIFT * (NUM_SEL - 1));
  localparam int              CNT_W    = $clog2(MAX_TERM + 1);

  // Synchronizer and edge detector
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], strobeIn};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  // Terminal count table, one entry per select value
  logic [CNT_W-1:0] termTab [NUM_SEL];
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_term
    assign termTab[i] = CNT_W'(BASE_TICKS << (SEL_SHIFT * i));
  end

  logic [CNT_W-1:0] termSel;
  assign termSel = termTab[timeoutSel];

  // Saturating counter
  logic [CNT_W-1:0] countQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      countQ <= '0;
    end else if (ctl.clear) begin
      countQ <= '0;
    end else if (ctl.advance) begin
      countQ <= countQ + CNT_W'(1);
    end
  end

  assign stat.edgeSeen = syncQ[SYNC_STAGES-1] ^ prevQ;
  assign stat.nearTerm = (countQ == termSel - CNT_W'(1));
  assign stat.atTerm   = (countQ >= termSel);

  // A detected level change empties the counter on the next edge
  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat.edgeSeen |=> (countQ == '0)); // R3

  // Once at the terminal value, the count stays put until cleared
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.atTerm && !ctl.clear) |=> $stable(countQ)); // R8

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wdDisable,
  input  logic     rstActive,
  input  wdtStat_t stat,
  output wdtCtl_t  ctl,
  output logic     timeoutReq
);

  logic fire;

  always_comb begin
    ctl.clear   = rstActive | stat.edgeSeen;
    ctl.advance = !ctl.clear && !stat.atTerm;
    fire        = ctl.advance && stat.nearTerm && !wdDisable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeoutReq <= 1'b0;
    end else begin
      timeoutReq <= fire;
    end
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeoutReq |=> !timeoutReq); // R8

  AST_MASKED_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    timeoutReq |-> !$past(wdDisable)); // R7

  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    rstActive |=> !timeoutReq); // R5

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter longint unsigned BASE_TICKS  = 64'd1_575_000, // shortest period, in clock cycles
  parameter int              SEL_SHIFT   = 4,
  parameter int              SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobeIn,
  input  logic       wdDisable,
  input  logic       rstActive,
  input  logic [1:0] timeoutSel,
  output logic       timeoutReq
);

  import wdt_pkg::*;

  wdtCtl_t  ctl;
  wdtStat_t stat;

  wdt_datapath #(
    .BASE_TICKS (BASE_TICKS),
    .SEL_W      (2),
    .SEL_SHIFT  (SEL_SHIFT),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobeIn  (strobeIn),
    .timeoutSel(timeoutSel),
    .ctl       (ctl),
    .stat      (stat)
  );

  wdt_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdDisable (wdDisable),
    .rstActive (rstActive),
    .stat      (stat),
    .ctl       (ctl),
    .timeoutReq(timeoutReq)
  );

endmodule

// File: tb/strobe_watchdog_tb_top.sv
module strobe_watchdog_tb_top;

  localparam int BASE = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       strobeIn;
  logic       wdDisable;
  logic       rstActive;
  logic [1:0] timeoutSel;
  logic       timeoutReq;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2 clk = ~clk; // 250 MHz

  strobe_watchdog #(.BASE_TICKS(BASE)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobeIn  (strobeIn),
    .wdDisable (wdDisable),
    .rstActive (rstActive),
    .timeoutSel(timeoutSel),
    .timeoutReq(timeoutReq)
  );

  // Vectors: {sel[1:0], disable, expectFire}
  localparam logic [3:0] VEC [6] = '{
    {2'd0, 1'b0, 1'b1},
    {2'd1, 1'b0, 1'b1},
    {2'd0, 1'b1, 1'b0},
    {2'd2, 1'b0, 1'b1},
    {2'd1, 1'b1, 1'b0},
    {2'd2, 1'b1, 1'b0}
  };

  function automatic int termOf(int s);
    return BASE << (4 * s);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count falling edges; report index of first high request and pulse count
  task automatic waitReq(int n, output int first, output int pulses);
    first  = -1;
    pulses = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (timeoutReq) begin
        if (first < 0) first = k;
        pulses++;
      end
    end
  endtask

  task automatic holdReset(int n);
    rstActive = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int f, n;
    rst_n      = 1'b0;
    strobeIn   = 1'b0;
    wdDisable  = 1'b0;
    rstActive  = 1'b1;
    timeoutSel = 2'd0;
    repeat (3) @(negedge clk);
    chk("R10 req low in reset", int'(timeoutReq), 0);
    rst_n = 1'b1;
    waitReq(20, f, n);
    chk("R10 R5 quiet while rstActive", n, 0);

    // Table walk
    foreach (VEC[i]) begin
      holdReset(2);
      timeoutSel = VEC[i][3:2];
      wdDisable  = VEC[i][1];
      @(negedge clk);
      rstActive = 1'b0;
      waitReq(2 * termOf(VEC[i][3:2]) + 6, f, n);
      if (VEC[i][0]) begin
        chk("R1 R2 latency", f, termOf(VEC[i][3:2]));
        chk("R8 single pulse", n, 1);
      end else begin
        chk("R7 masked by disable", n, 0);
      end
    end
    wdDisable = 1'b0;

    // Longest option
    holdReset(2);
    timeoutSel = 2'd3;
    @(negedge clk);
    rstActive = 1'b0;
    waitReq(termOf(3) + 20, f, n);
    chk("R2 sel3 latency", f, termOf(3));

    // Keep-alive by toggling
    holdReset(2);
    timeoutSel = 2'd0;
    rstActive  = 1'b0;
    strobeIn   = ~strobeIn;
    for (int t = 0; t < 21; t++) begin
      waitReq(8, f, n);
      chk("R3 R4 toggling keeps quiet", n, 0);
      strobeIn = ~strobeIn;
    end
    // strobeIn is now 0 after an odd number of toggles from 0 plus one
    if (strobeIn) begin
      waitReq(8, f, n);
      strobeIn = 1'b0;
    end
    waitReq(2, f, n);
    strobeIn = 1'b1;  // rising
    waitReq(30, f, n);
    chk("R3 rising clears", f, 3 + termOf(0));
    strobeIn = 1'b0;  // falling, from saturation
    waitReq(30, f, n);
    chk("R4 falling clears", f, 3 + termOf(0));

    // Single-cycle pulse
    strobeIn = 1'b1;
    @(negedge clk);
    strobeIn = 1'b0;
    waitReq(30, f, n);
    chk("R9 one-cycle pulse", f, 3 + termOf(0));

    // Reset holds the counter at zero
    holdReset(1);
    waitReq(50, f, n);
    chk("R5 no req during long reset", n, 0);
    rstActive = 1'b0;
    waitReq(30, f, n);
    chk("R5 restart after reset", f, termOf(0));

    // Saturation, then own-timeout reset
    waitReq(40, f, n);
    chk("R8 no repeat while saturated", n, 0);
    holdReset(4);
    rstActive = 1'b0;
    waitReq(30, f, n);
    chk("R6 reset after own timeout", f, termOf(0));
    chk("R6 R8 one pulse", n, 1);

    // Disable masks but counter keeps running
    holdReset(2);
    wdDisable = 1'b1;
    rstActive = 1'b0;
    waitReq(5, f, n);
    chk("R7 quiet while disabled", n, 0);
    wdDisable = 1'b0;
    waitReq(20, f, n);
    chk("R7 counter kept running", f, termOf(0) - 5);

    holdReset(2);
    wdDisable = 1'b1;
    rstActive = 1'b0;
    waitReq(15, f, n);
    chk("R7 disabled through terminal", n, 0);
    wdDisable = 1'b0;
    waitReq(20, f, n);
    chk("R7 R8 no late request", n, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule